// File: doc/BRIEF.md
# Periodic / One-Shot Alarm Comparator

This block is a single alarm channel. It watches one of two free-running 52-bit count values and raises an interrupt when the watched count reaches a programmed alarm point. In one-shot mode it fires once. In periodic mode it moves its alarm point forward by a 26-bit period after every hit, so the alarm repeats.

Software writes a staged target (a 20-bit upper part and a 32-bit lower part), a staged period, a mode bit and a source-select bit. None of these values reach the comparator until the load strobe is pulsed. At that point the channel takes the whole configuration and arms itself. A work-enable bit gates alarm generation. The interrupt path has three parts: a sticky raw flag, a write-one-to-clear bit and an enable mask. The masked status drives a level-sensitive interrupt line.

The block has no data stream, so every pin is a plain control or status signal and none has a valid/ready handshake.

Top module: `alm_channel`

## Requirements
- R1: While reset is held, and after it is released, `raw_flag`, `int_stat` and `irq` are 0 and the channel is disarmed. A disarmed channel raises no alarm at any count value.
- R2: A one-cycle pulse on `load` captures the 52-bit target `{tgt_hi, tgt_lo}`, with `tgt_hi` as bits 51:32. A one-shot channel hits in any cycle where the selected count minus the active target, taken modulo 2^52, has bit 51 clear. In other words, the count has reached or passed the target.
- R3: In one-shot mode (`periodic`=0 at load), the channel hits once and then stays disarmed until the next `load`.
- R4: The value of `src_sel` at load is captured. 0 compares `cnt_a` and 1 compares `cnt_b`. The other count has no effect.
- R5: Changes to `tgt_hi`, `tgt_lo`, `period`, `periodic` or `src_sel` without a `load` pulse have no effect on alarms.
- R6: While `work_en` is 0, no hit occurs and `raw_flag` is not set. The armed alarm point is kept.
- R7: In periodic mode (`periodic`=1 at load), the first alarm point is the selected count at load plus `period`. Each hit advances the alarm point by `period`, modulo 2^52.
- R8: A hit sets `raw_flag` at the next clock edge. Writing 1 to `int_clr` clears it at the next edge. If a hit and a clear happen in the same cycle, the flag stays set.
- R9: `int_stat` equals `raw_flag` AND `int_en`, and `irq` equals `int_stat`. `int_en` never changes `raw_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_a | input | 52 | First live count value |
| cnt_b | input | 52 | Second live count value |
| src_sel | input | 1 | Staged source select (0: cnt_a, 1: cnt_b) |
| tgt_hi | input | 20 | Staged target, bits 51:32 |
| tgt_lo | input | 32 | Staged target, bits 31:0 |
| period | input | 26 | Staged period |
| periodic | input | 1 | Staged mode (1: periodic, 0: one-shot) |
| work_en | input | 1 | Alarm generation enable |
| load | input | 1 | Strobe that adopts the staged configuration and arms |
| int_en | input | 1 | Interrupt mask enable |
| int_clr | input | 1 | Write-one-to-clear for the raw flag |
| raw_flag | output | 1 | Sticky raw interrupt flag |
| int_stat | output | 1 | Masked interrupt status |
| irq | output | 1 | Level interrupt line |

## Verification
The comparison is exercised in several ways:
- A count that approaches the target from below, hits it exactly, and moves past it, in both modes. This separates "reached" from "passed" and from a single re-fire.
- A large value on the unselected count. This tells whether the captured source select is the one being used.
- A staged target of zero left without a load, and a work-enable dropped while the count is past the alarm point. These show that neither reaches the comparator.
- A target that needs its upper part, and a periodic reload near the top of the count range whose alarm point wraps. These separate a true 52-bit, modulo-aware comparison from a truncated or plain magnitude compare.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int CNT_W = 52;
  localparam int LO_W  = 32;
  localparam int PER_W = 26;
endpackage

// File: rtl/alm_arm.sv
module alm_arm #(
  parameter int CNT_W = alm_pkg::CNT_W,
  parameter int PER_W = alm_pkg::PER_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_a,
  input  logic [CNT_W-1:0] cnt_b,
  input  logic             src_sel,
  input  logic [CNT_W-1:0] tgt_in,
  input  logic [PER_W-1:0] per_in,
  input  logic             periodic,
  input  logic             load,
  input  logic             hit,
  output logic [CNT_W-1:0] tgt_q,
  output logic             src_q,
  output logic             armed_q
);
  logic [PER_W-1:0] per_q;
  logic             mode_q;
  logic [CNT_W-1:0] load_cnt;

  assign load_cnt = src_sel ? cnt_b : cnt_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q   <= '0;
      per_q   <= '0;
      mode_q  <= 1'b0;
      src_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (load) begin
      src_q   <= src_sel;
      mode_q  <= periodic;
      per_q   <= per_in;
      armed_q <= 1'b1;
      tgt_q   <= periodic ? load_cnt + CNT_W'(per_in) : tgt_in;
    end else if (hit) begin
      if (mode_q) tgt_q   <= tgt_q + CNT_W'(per_q);
      else        armed_q <= 1'b0;
    end
  end

  // R3: a one-shot hit disarms the channel
  a_r3_oneshot_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !load && !mode_q |=> !armed_q);
  // R5: the alarm point moves only on load or a hit
  a_r5_target_held: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !hit |=> $stable(tgt_q) && $stable(src_q));
  // R7: a periodic hit advances the alarm point by the period
  a_r7_period_advance: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !load && mode_q |=> tgt_q == $past(tgt_q) + CNT_W'($past(per_q)));
endmodule

// File: rtl/alm_match.sv
module alm_match #(
  parameter int CNT_W = alm_pkg::CNT_W
) (
  input  logic [CNT_W-1:0] cnt_a,
  input  logic [CNT_W-1:0] cnt_b,
  input  logic             src_q,
  input  logic [CNT_W-1:0] tgt_q,
  input  logic             armed_q,
  input  logic             work_en,
  output logic             hit
);
  logic [CNT_W-1:0] cur;
  logic [CNT_W-1:0] diff;

  assign cur  = src_q ? cnt_b : cnt_a;
  assign diff = cur - tgt_q;
  // the count is at or past the target when the modular difference is non-negative
  assign hit  = armed_q & work_en & ~diff[CNT_W-1];
endmodule

// File: rtl/alm_irq.sv
module alm_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic int_clr,
  input  logic int_en,
  output logic raw_q,
  output logic stat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= 1'b0;
    else        raw_q <= hit | (raw_q & ~int_clr);
  end

  assign stat = raw_q & int_en;

  // R8: a hit always leaves the flag set, even with a clear in the same cycle
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> raw_q);
  // R8: a clear without a hit drops the flag
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    raw_q && int_clr && !hit |=> !raw_q);
  // R9: the flag rises only through a hit, whatever the mask does
  a_r9_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_q && !hit |=> !raw_q);
endmodule

// File: rtl/alm_channel.sv
module alm_channel #(
  parameter int CNT_W = alm_pkg::CNT_W,
  parameter int LO_W  = alm_pkg::LO_W,
  parameter int PER_W = alm_pkg::PER_W,
  localparam int HI_W = CNT_W - LO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_a,
  input  logic [CNT_W-1:0] cnt_b,
  input  logic             src_sel,
  input  logic [HI_W-1:0]  tgt_hi,
  input  logic [LO_W-1:0]  tgt_lo,
  input  logic [PER_W-1:0] period,
  input  logic             periodic,
  input  logic             work_en,
  input  logic             load,
  input  logic             int_en,
  input  logic             int_clr,
  output logic             raw_flag,
  output logic             int_stat,
  output logic             irq
);
  logic [CNT_W-1:0] tgt_q;
  logic             src_q;
  logic             armed_q;
  logic             hit;

  alm_arm #(.CNT_W(CNT_W), .PER_W(PER_W)) u_arm (
    .clk(clk), .rst_n(rst_n), .cnt_a(cnt_a), .cnt_b(cnt_b),
    .src_sel(src_sel), .tgt_in({tgt_hi, tgt_lo}), .per_in(period),
    .periodic(periodic), .load(load), .hit(hit),
    .tgt_q(tgt_q), .src_q(src_q), .armed_q(armed_q)
  );

  alm_match #(.CNT_W(CNT_W)) u_match (
    .cnt_a(cnt_a), .cnt_b(cnt_b), .src_q(src_q), .tgt_q(tgt_q),
    .armed_q(armed_q), .work_en(work_en), .hit(hit)
  );

  alm_irq u_irq (
    .clk(clk), .rst_n(rst_n), .hit(hit), .int_clr(int_clr),
    .int_en(int_en), .raw_q(raw_flag), .stat(int_stat)
  );

  assign irq = int_stat;

  // R6: with work enable low the raw flag cannot newly rise
  a_r6_work_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !work_en && !raw_flag |=> !raw_flag);
  // R1: a disarmed channel never raises the flag
  a_r1_disarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q && !raw_flag |=> !raw_flag);
endmodule

// File: tb/tb_alm_channel.sv
`timescale 1ns/1ps
module tb_alm_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [51:0] cnt_a = '0, cnt_b = '0;
  logic        src_sel = 1'b0;
  logic [19:0] tgt_hi = '0;
  logic [31:0] tgt_lo = '0;
  logic [25:0] period = '0;
  logic        periodic = 1'b0, work_en = 1'b0, load = 1'b0, int_en = 1'b0, int_clr = 1'b0;
  logic        raw_flag, int_stat, irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alm_channel dut (
    .clk(clk), .rst_n(rst_n), .cnt_a(cnt_a), .cnt_b(cnt_b), .src_sel(src_sel),
    .tgt_hi(tgt_hi), .tgt_lo(tgt_lo), .period(period), .periodic(periodic),
    .work_en(work_en), .load(load), .int_en(int_en), .int_clr(int_clr),
    .raw_flag(raw_flag), .int_stat(int_stat), .irq(irq)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [51:0] a;
    logic [51:0] b;
    logic        sel;
    logic [51:0] tgt;
    logic [25:0] per;
    logic        pm, we, ld, ie, clr, er, es;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{8'd2, 52'd100,  52'd0,  1'b0, 52'd200, 26'd0, 1'b0,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0}, // R2 load one-shot, target 200
    '{8'd2, 52'd150,  52'd0,  1'b0, 52'd200, 26'd0, 1'b0,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0}, // R2 below target
    '{8'd2, 52'd200,  52'd0,  1'b0, 52'd200, 26'd0, 1'b0,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1}, // R2 exact hit
    '{8'd8, 52'd250,  52'd0,  1'b0, 52'd200, 26'd0, 1'b0,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b0}, // R8 clear
    '{8'd3, 52'd300,  52'd0,  1'b0, 52'd200, 26'd0, 1'b0,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0}, // R3 no refire
    '{8'd4, 52'd0,    52'd10, 1'b1, 52'd50,  26'd0, 1'b0,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0}, // R4 load, source b
    '{8'd4, 52'd1000, 52'd40, 1'b1, 52'd50,  26'd0, 1'b0,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0}, // R4 count a ignored
    '{8'd9, 52'd1000, 52'd60, 1'b1, 52'd50,  26'd0, 1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0}, // R9 masked
    '{8'd9, 52'd1000, 52'd70, 1'b1, 52'd50,  26'd0, 1'b0,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1}, // R9 unmasked
    '{8'd7, 52'd20,   52'd0,  1'b0, 52'd0,   26'd5, 1'b1,1'b0,1'b1,1'b1,1'b1, 1'b0,1'b0}, // R7 periodic load, alarm 25
    '{8'd6, 52'd30,   52'd0,  1'b0, 52'd0,   26'd5, 1'b1,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0}, // R6 work gated
    '{8'd6, 52'd30,   52'd0,  1'b0, 52'd0,   26'd5, 1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1}, // R6 alarm kept, fires
    '{8'd8, 52'd30,   52'd0,  1'b0, 52'd0,   26'd5, 1'b1,1'b1,1'b0,1'b1,1'b1, 1'b1,1'b1}, // R8 set wins over clear
    '{8'd7, 52'd31,   52'd0,  1'b0, 52'd0,   26'd5, 1'b1,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b0}, // R7 before 35
    '{8'd7, 52'd35,   52'd0,  1'b0, 52'd0,   26'd5, 1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1}, // R7 hit 35
    '{8'd7, 52'd36,   52'd0,  1'b0, 52'd0,   26'd5, 1'b1,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b0}, // R7 clear
    '{8'd7, 52'd39,   52'd0,  1'b0, 52'd0,   26'd5, 1'b1,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0}, // R7 before 40
    '{8'd7, 52'd40,   52'd0,  1'b0, 52'd0,   26'd5, 1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1}, // R7 hit 40
    '{8'd5, 52'd41,   52'd0,  1'b0, 52'd0,   26'd1, 1'b0,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b0}, // R5 staged target 0 ignored
    '{8'd5, 52'd44,   52'd0,  1'b0, 52'd0,   26'd1, 1'b0,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0}, // R5 still at 45
    '{8'd5, 52'd45,   52'd0,  1'b0, 52'd0,   26'd1, 1'b0,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1}  // R5 old period kept
  };

  task automatic chk(input int req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL R%0d %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: held in reset
    chk(1, "raw in reset", raw_flag, 1'b0);
    chk(1, "irq in reset", irq, 1'b0);
    rst_n = 1'b1;
    tick();
    chk(1, "raw after reset", raw_flag, 1'b0);

    for (int i = 0; i < NV; i++) begin
      cnt_a = VEC[i].a; cnt_b = VEC[i].b; src_sel = VEC[i].sel;
      {tgt_hi, tgt_lo} = VEC[i].tgt; period = VEC[i].per;
      periodic = VEC[i].pm; work_en = VEC[i].we; load = VEC[i].ld;
      int_en = VEC[i].ie; int_clr = VEC[i].clr;
      tick();
      chk(VEC[i].req, $sformatf("row %0d raw", i), raw_flag, VEC[i].er);
      chk(VEC[i].req, $sformatf("row %0d stat", i), int_stat, VEC[i].es);
      chk(9, $sformatf("row %0d irq", i), irq, VEC[i].es);
    end
    load = 1'b0; int_clr = 1'b0;

    // R1: reset mid-run clears the flag and disarms
    rst_n = 1'b0;
    #1;
    chk(1, "raw async reset", raw_flag, 1'b0);
    chk(1, "stat async reset", int_stat, 1'b0);
    tick();
    rst_n = 1'b1;
    cnt_a = 52'd1000; work_en = 1'b1; int_en = 1'b1;
    tick(); tick();
    chk(1, "disarmed after reset", raw_flag, 1'b0);

    // R2: target needs its upper part
    tgt_hi = 20'd1; tgt_lo = 32'd0; periodic = 1'b0; src_sel = 1'b0;
    cnt_a = 52'd0; load = 1'b1;
    tick();
    load = 1'b0; cnt_a = 52'h0_0000_FFFF_FFFF;
    tick();
    chk(2, "below 2^32", raw_flag, 1'b0);
    cnt_a = 52'h0_0001_0000_0000;
    tick();
    chk(2, "at 2^32", raw_flag, 1'b1);
    int_clr = 1'b1;
    tick();
    int_clr = 1'b0;
    chk(8, "cleared", raw_flag, 1'b0);

    // R7: periodic alarm point wraps modulo 2^52
    cnt_a = 52'hF_FFFF_FFFF_FFFD; period = 26'd5; periodic = 1'b1; load = 1'b1;
    tick();
    load = 1'b0; cnt_a = 52'hF_FFFF_FFFF_FFFF;
    tick();
    chk(7, "wrap before top", raw_flag, 1'b0);
    cnt_a = 52'd1;
    tick();
    chk(7, "wrap at 1", raw_flag, 1'b0);
    cnt_a = 52'd2;
    tick();
    chk(7, "wrap at 2", raw_flag, 1'b1);

    finish_run();
  end
endmodule